// File: doc/BRIEF.md
# Dual-Rail Line Code Decoder with Violation Flagging

This block takes received line data as two rails, one flag for a positive pulse and one for a negative pulse, one bit per accepted beat, and turns it into single-rail NRZ data together with a code-violation flag. A mode input picks one of two decoding rules. The first is plain alternate-mark-inversion checking. The second also recognises the four-bit zero-substitution patterns of the high-density bipolar code, returns them to zeros, and flags only the polarity violations that no legal substitution explains.

A rail-select input decides whether the block decodes or forwards the two rails unchanged. It is filtered: decoding starts only after the select has been seen high on more than 16 consecutive clock cycles, and a low select returns the block to forwarding at once.

Both data sides are valid/ready streams. An input beat is taken when `in_valid` and `in_ready` are high on the same rising edge. `in_ready` is high whenever the output register is empty or is being emptied in that cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no input is taken. Every taken beat is one bit time. A bit appears at the output once three later bits have been taken, so the last three bits stay inside until more data follows.

Top module: `linecode_rx_dec`

## Requirements
- R1: In decode mode, `out_a` carries the data: 1 for a bit with either rail high (a mark) and 0 for a bit with both rails low (a space).
- R2: With `hdb_en` low, a mark of the same polarity as the previous mark sets `out_b` (the violation flag) for that bit only. The bits around it are not flagged.
- R3: The first mark after reset is never flagged, whatever its polarity.
- R4: With `hdb_en` high, a same-polarity mark that follows three spaces (pattern 0,0,0,V) is output as a 0 and is not flagged. A same-polarity mark that follows two spaces and one earlier mark (pattern B,0,0,V) is also output as a 0 and is not flagged, and so is that earlier mark B.
- R5: With `hdb_en` high, a same-polarity mark that fits neither pattern of R4 is output as a 1 with `out_b` set for that bit.
- R6: With `hdb_en` high, a run of four or more consecutive spaces sets `out_b` on every bit of the run and on no bit outside it. With `hdb_en` low, runs of spaces are never flagged.
- R7: A bit with both rails high is output as data 1 with `out_b` set. The polarity remembered for later checks is left unchanged.
- R8: Decode mode takes effect only after `uni_sel` has been sampled high on 17 consecutive rising edges. An output loaded on the 17th of those edges is still forwarded. A low `uni_sel` returns the block to forwarding from the next edge.
- R9: In forwarding mode, `out_a` equals the positive rail and `out_b` equals the negative rail of each bit, with the same three-bit delay and in the same order.
- R10: `in_ready` equals `!out_valid || out_ready`. A stalled output keeps its value. After reset, `out_valid` stays low until the fourth bit has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdb_en | input | 1 | 1: substitution-aware decoding, 0: plain alternate-mark checking |
| uni_sel | input | 1 | Rail select, filtered: high for decoding, low for forwarding |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on this edge when high |
| in_pos | input | 1 | Positive-pulse rail of the bit |
| in_neg | input | 1 | Negative-pulse rail of the bit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_a | output | 1 | Decoded data, or the positive rail when forwarding |
| out_b | output | 1 | Violation flag, or the negative rail when forwarding |

## Verification
The hardest case to reach from the ports is the B,0,0,V substitution. Its leading mark must be cleared at the very beat it leaves the three-bit window, so the stimulus sets up that polarity history and a three-deep window before the V arrives. The select filter boundary is also hard to reach: the window is first filled in forwarding mode, then the bench counts idle cycles after raising the select, so that the next output load falls exactly on the 17th or 18th high sample. Stall handling is checked by holding `out_ready` low while the window is full and confirming that the held output and a low `in_ready` persist.

// File: rtl/hdb_pkg.sv
package hdb_pkg;

  // Depth of the look-back window; the four-bit substitution patterns need three.
  localparam int unsigned WIN = 3;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_POS  = 2'd1,
    POL_NEG  = 2'd2
  } pol_e;

  // One bit time travelling through the window.
  typedef struct packed {
    logic vld;   // slot holds a real bit
    logic rp;    // raw positive rail
    logic rn;    // raw negative rail
    logic mark;  // a pulse was on the line
    logic data;  // decoded value (substituted marks cleared)
    logic viol;  // violation flag for this bit
  } slot_t;

endpackage

// File: rtl/hdb_sel_qual.sv
module hdb_sel_qual #(
  parameter int unsigned QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic uni_mode
);

  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      uni_mode <= 1'b0;
    end else if (!sel) begin
      cnt_q    <= '0;
      uni_mode <= 1'b0;
    end else if (cnt_q == LIMIT) begin
      uni_mode <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_SEL_LOW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !uni_mode); // R8
  AST_MODE_RISE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uni_mode) |-> sel && $past(sel)); // R8

endmodule

// File: rtl/hdb_window.sv
module hdb_window
  import hdb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift,
  input  slot_t [WIN-1:0]     nxt,
  output slot_t [WIN-1:0]     win
);

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     win[g] <= '0;
      else if (shift) win[g] <= nxt[g];
    end
  end

endmodule

// File: rtl/hdb_code_check.sv
module hdb_code_check
  import hdb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            hdb_en,
  input  logic            in_pos,
  input  logic            in_neg,
  input  slot_t [WIN-1:0] win,
  output slot_t [WIN:0]   nxt
);

  pol_e last_q;
  logic mark, both, same;
  logic all_space, lead_space, far_mark;

  always_comb begin
    mark = in_pos | in_neg;
    both = in_pos & in_neg;
    same = mark && !both &&
           ((in_pos && last_q == POL_POS) || (in_neg && last_q == POL_NEG));
    all_space = 1'b1;
    for (int i = 0; i < WIN; i++)
      if (!win[i].vld || win[i].mark) all_space = 1'b0;
    lead_space = 1'b1;
    for (int i = 0; i < WIN - 1; i++)
      if (!win[i].vld || win[i].mark) lead_space = 1'b0;
    far_mark = win[WIN-1].vld && win[WIN-1].mark;
  end

  always_comb begin
    nxt[0].vld  = 1'b1;
    nxt[0].rp   = in_pos;
    nxt[0].rn   = in_neg;
    nxt[0].mark = mark;
    nxt[0].data = mark;
    nxt[0].viol = 1'b0;
    for (int i = 1; i <= WIN; i++) nxt[i] = win[i-1];

    if (both) begin
      nxt[0].viol = 1'b1;
    end else if (same) begin
      if (hdb_en && all_space) begin
        nxt[0].data = 1'b0;                 // 0,0,0,V
      end else if (hdb_en && lead_space && far_mark) begin
        nxt[0].data   = 1'b0;               // B,0,0,V
        nxt[WIN].data = 1'b0;
      end else begin
        nxt[0].viol = 1'b1;
      end
    end

    if (hdb_en && !mark && all_space)
      for (int i = 0; i <= WIN; i++) nxt[i].viol = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       last_q <= POL_NONE;
    else if (accept && mark && !both) last_q <= in_pos ? POL_POS : POL_NEG;
  end

  AST_SUB_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hdb_en && nxt[0].mark && !nxt[0].data |-> !nxt[0].viol); // R4
  AST_FIRST_MARK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && last_q == POL_NONE && (in_pos != in_neg) |-> !nxt[0].viol); // R3
  AST_PLAIN_NO_RUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hdb_en && !in_pos && !in_neg |-> !nxt[0].viol); // R6

endmodule

// File: rtl/linecode_rx_dec.sv
module linecode_rx_dec
  import hdb_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdb_en,
  input  logic uni_sel,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_pos,
  input  logic in_neg,
  output logic out_valid,
  input  logic out_ready,
  output logic out_a,
  output logic out_b
);

  logic            uni_mode;
  logic            accept;
  slot_t [WIN-1:0] win;
  slot_t [WIN:0]   nxt;
  slot_t           leaving;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign leaving  = nxt[WIN];

  hdb_sel_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (uni_sel),
    .uni_mode (uni_mode)
  );

  hdb_code_check u_check (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .hdb_en (hdb_en),
    .in_pos (in_pos),
    .in_neg (in_neg),
    .win    (win),
    .nxt    (nxt)
  );

  hdb_window u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (accept),
    .nxt   (nxt[WIN-1:0]),
    .win   (win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_a     <= 1'b0;
      out_b     <= 1'b0;
    end else if (accept) begin
      out_valid <= leaving.vld;
      out_a     <= uni_mode ? leaving.data : leaving.rp;
      out_b     <= uni_mode ? leaving.viol : leaving.rn;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_a) && $stable(out_b)); // R10
  AST_DATA_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && leaving.vld && leaving.data |-> leaving.mark); // R1

endmodule

// File: tb/linecode_rx_dec_bench.sv
`timescale 1ns/1ps
module linecode_rx_dec_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdb_en = 1'b0, uni_sel = 1'b0;
  logic in_valid = 1'b0, in_pos = 1'b0, in_neg = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_a, out_b;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit    a;
    bit    b;
    bit    chk;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  linecode_rx_dec u_linecode_rx_dec (
    .clk(clk), .rst_n(rst_n), .hdb_en(hdb_en), .uni_sel(uni_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_pos(in_pos), .in_neg(in_neg),
    .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_b(out_b)
  );

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: a transfer happens on the edge after this sampling point.
  always begin
    @(negedge clk);
    #5;
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10: unexpected output actual=%b%b expected=none", out_a, out_b);
      end else begin
        exp_t e = q.pop_front();
        if (e.chk) check(e.tag, {out_a, out_b}, {e.a, e.b});
      end
    end
  end

  // Driver: called at a falling edge, returns at the falling edge after acceptance.
  task automatic send(bit p, bit n, bit ea, bit eb, bit chk, string tag);
    bit rdy;
    q.push_back('{a: ea, b: eb, chk: chk, tag: tag});
    in_valid = 1'b1; in_pos = p; in_neg = n;
    do begin
      #1;
      rdy = in_ready;
      @(negedge clk);
    end while (!rdy);
    in_valid = 1'b0; in_pos = 1'b0; in_neg = 1'b0;
  endtask

  task automatic u(bit p, bit n, bit ea, bit eb, string tag);
    send(p, n, ea, eb, 1'b1, tag);
  endtask

  task automatic x(bit p, bit n);
    send(p, n, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic do_reset(bit sel, bit hdb, int settle);
    @(negedge clk);
    rst_n = 1'b0; uni_sel = sel; hdb_en = hdb; in_valid = 1'b0; out_ready = 1'b1;
    q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Reset state and latency (R10), plain alternate-mark rules
    do_reset(1'b1, 1'b0, 20);
    #1 check("R10 reset out_valid/in_ready", {out_valid, in_ready}, 2'b01);
    u(1,0, 1,0, "R3 first mark");
    u(0,0, 0,0, "R1 space");
    u(0,1, 1,0, "R1 neg mark");
    #1 check("R10 no output before 4th bit", {1'b0, out_valid}, 2'b00);
    u(1,0, 1,0, "R1 pos mark");
    #1 check("R10 output after 4th bit", {1'b0, out_valid}, 2'b01);
    u(1,0, 1,1, "R2 same polarity");
    for (int i = 0; i < 5; i++) u(0,0, 0,0, "R6 plain run not flagged");
    u(0,1, 1,0, "R1 alternation");
    u(0,1, 1,1, "R2 repeated neg");
    x(0,0); x(0,0); x(0,0);

    // Substitution patterns (R4, R5)
    do_reset(1'b1, 1'b1, 20);
    u(0,1, 1,0, "R3 first neg mark");
    u(1,0, 1,0, "R1 alternation");
    u(0,0, 0,0, "R4 000V zero");
    u(0,0, 0,0, "R4 000V zero");
    u(0,0, 0,0, "R4 000V zero");
    u(1,0, 0,0, "R4 000V V cleared");
    u(0,1, 0,0, "R4 B00V B cleared");
    u(0,0, 0,0, "R4 B00V zero");
    u(0,0, 0,0, "R4 B00V zero");
    u(0,1, 0,0, "R4 B00V V cleared");
    u(1,0, 1,0, "R1 after substitution");
    u(1,0, 1,1, "R5 adjacent same polarity");
    u(0,1, 1,0, "R1 alternation");
    u(0,0, 0,0, "R1 space");
    u(0,1, 1,1, "R5 B0V not a substitution");
    x(1,0); x(0,1); x(1,0);

    // Zero runs (R6)
    do_reset(1'b1, 1'b1, 20);
    u(1,0, 1,0, "R3 first mark");
    for (int i = 0; i < 3; i++) u(0,0, 0,0, "R6 three spaces unflagged");
    u(0,1, 1,0, "R1 alternation");
    for (int i = 0; i < 5; i++) u(0,0, 0,1, "R6 long run flagged");
    u(1,0, 1,0, "R6 mark after run unflagged");
    x(0,1); x(1,0); x(0,1);

    // Both rails high (R7)
    do_reset(1'b1, 1'b0, 20);
    u(1,0, 1,0, "R3 first mark");
    u(1,1, 1,1, "R7 both rails");
    u(1,0, 1,1, "R7 polarity kept");
    u(0,1, 1,0, "R1 alternation");
    x(0,0); x(0,0); x(0,0);

    // Forwarding and stall (R9, R10)
    do_reset(1'b0, 1'b1, 2);
    u(1,0, 1,0, "R9 pos forwarded");
    u(0,1, 0,1, "R9 neg forwarded");
    u(0,0, 0,0, "R9 space forwarded");
    u(1,1, 1,1, "R9 both forwarded");
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R10 stalled valid/ready", {out_valid, in_ready}, 2'b10);
    check("R10 stalled output held", {out_a, out_b}, 2'b10);
    out_ready = 1'b1;
    u(1,0, 1,0, "R9 repeat pos forwarded");
    u(1,0, 1,0, "R9 repeat pos forwarded");
    x(0,0); x(0,0); x(0,0);

    // Select qualification: 17th sample still forwards (R8)
    do_reset(1'b0, 1'b0, 2);
    u(0,1, 0,1, "R8 load on 17th high sample forwards");
    x(0,0); x(0,0);
    uni_sel = 1'b1;
    repeat (16) @(negedge clk);
    x(0,0);
    x(0,0); x(0,0);

    // Select qualification: 18th sample decodes, low forwards again (R8)
    do_reset(1'b0, 1'b0, 2);
    u(0,1, 1,0, "R8 load on 18th high sample decodes");
    u(0,1, 0,1, "R8 low select forwards");
    x(0,0);
    uni_sel = 1'b1;
    repeat (17) @(negedge clk);
    x(0,0);
    uni_sel = 1'b0;
    @(negedge clk);
    x(0,0);
    x(0,0); x(0,0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule